// File: doc/BRIEF.md
# YUV Bus Output Formatter

This block drives a 16-bit digital video output bus from parallel luminance and colour-difference samples. The luminance byte passes straight through a register. The colour-difference byte is time-multiplexed. In the 4:2:2 arrangement it alternates whole U and V samples. In the 4:1:1 arrangement it spreads slices of one U/V pair over four consecutive samples. The block runs on a 27 MHz line-locked clock. A qualifying strobe marks every second edge, so data advances at 13.5 MHz.

A horizontal reference input frames the active part of each line. Its rising edge restarts the chroma multiplex at U and captures the format select. While it is low, the bus carries blanking levels. An active-low enable pin gates the drive enable handed to the sixteen pad buffers. The block never overwrites the data registers because of that enable.

Top module: `yuv_bus_fmt`

## Requirements
- R1: After reset, and before any qualified edge, y_out is 16 and uv_out is 128.
- R2: y_out and uv_out change only on clock edges where ref_q is high. On all other edges they hold their value.
- R3: On a qualified edge with href low, y_out becomes 16 and uv_out becomes 128.
- R4: On a qualified edge with href high, y_out becomes the y_in present at that edge, one clock of latency.
- R5: In 4:2:2 (fmt_sel = 0), uv_out carries U on the first qualified sample with href high, then V, and keeps alternating. The U and V sent in each pair are both taken at the pair's first sample.
- R6: In 4:1:1 (fmt_sel = 1), a frame spans four samples with phase p = 0..3. On phase p, uv_out[7:6] = U[7-2p:6-2p] and uv_out[5:4] = V[7-2p:6-2p], and uv_out[3:0] = 0. U and V are both taken at phase 0.
- R7: fmt_sel is taken only on the qualified edge where href is first seen high. A change during the line has no effect until the next line.
- R8: bus_oe is high exactly when oe_n is low, with no clock involved. oe_n has no effect on the y_out and uv_out values.
- R9: A new line always starts at phase 0 (U first), even if the previous line ended part way through a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz line-locked clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_q | input | 1 | Qualifying strobe; data advances on edges where it is high |
| href | input | 1 | Horizontal reference, high during active samples |
| fmt_sel | input | 1 | 0 = 4:2:2, 1 = 4:1:1 |
| oe_n | input | 1 | Active-low output enable pin |
| y_in | input | 8 | Luminance sample |
| u_in | input | 8 | U colour-difference sample |
| v_in | input | 8 | V colour-difference sample |
| y_out | output | 8 | Luminance byte of the output bus |
| uv_out | output | 8 | Multiplexed colour-difference byte |
| bus_oe | output | 1 | Drive enable for the 16 bus pad buffers |

## Verification
The hardest case to reach from the ports is a line that ends part way through a 4:1:1 frame, combined with a format change in the middle of a line and strobe gaps longer than one clock. In that case the held chroma, the phase counter and the latched format must all restart cleanly. The stimulus produces random href runs whose lengths are not multiples of four. It flips fmt_sel on every cycle and sometimes holds ref_q low for several clocks. Directed sequences add a three-sample 4:1:1 line followed directly by a new line, and a format toggle in mid-line.

// File: rtl/yuv_fmt_pkg.sv
package yuv_fmt_pkg;
   typedef enum logic {
      FMT_422 = 1'b0,
      FMT_411 = 1'b1
   } fmt_e;

   localparam int unsigned PHASES_411 = 4;
   localparam int unsigned PH_W       = 2;
endpackage

// File: rtl/yuv_phase_ctrl.sv
module yuv_phase_ctrl
   import yuv_fmt_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ref_q,
   input  logic            href,
   input  fmt_e            fmt_sel,
   output logic [PH_W-1:0] phase,
   output fmt_e            fmt_cur,
   output logic            line_start
);
   logic            href_q;
   logic [PH_W-1:0] phase_r;
   logic [PH_W-1:0] last_ph;
   fmt_e            fmt_r;

   always_comb begin
      line_start = href & ~href_q;
      phase      = line_start ? '0 : phase_r;
      fmt_cur    = line_start ? fmt_sel : fmt_r;
      last_ph    = (fmt_cur == FMT_411) ? PH_W'(PHASES_411 - 1) : PH_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         href_q  <= 1'b0;
         phase_r <= '0;
         fmt_r   <= FMT_422;
      end else if (ref_q) begin
         href_q <= href;
         fmt_r  <= fmt_cur;
         if (!href || phase == last_ph) phase_r <= '0;
         else                           phase_r <= phase + 1'b1;
      end
   end
endmodule

// File: rtl/yuv_chroma_pack.sv
module yuv_chroma_pack
   import yuv_fmt_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic [DW-1:0]   u_sel,
   input  logic [DW-1:0]   v_sel,
   input  logic [PH_W-1:0] phase,
   input  fmt_e            fmt,
   output logic [DW-1:0]   uv
);
   localparam int unsigned Q = DW / PHASES_411;

   logic [DW-1:0] slice [PHASES_411];

   generate
      for (genvar p = 0; p < PHASES_411; p++) begin : g_slice
         assign slice[p] = {u_sel[DW-1-p*Q -: Q], v_sel[DW-1-p*Q -: Q], {(DW/2){1'b0}}};
      end
   endgenerate

   always_comb begin
      if (fmt == FMT_411) uv = slice[phase];
      else                uv = phase[0] ? v_sel : u_sel;
   end
endmodule

// File: rtl/yuv_bus_fmt.sv
module yuv_bus_fmt
   import yuv_fmt_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter logic [7:0]  Y_BLANK = 8'd16,
   parameter logic [7:0]  C_BLANK = 8'd128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ref_q,
   input  logic          href,
   input  logic          fmt_sel,
   input  logic          oe_n,
   input  logic [DW-1:0] y_in,
   input  logic [DW-1:0] u_in,
   input  logic [DW-1:0] v_in,
   output logic [DW-1:0] y_out,
   output logic [DW-1:0] uv_out,
   output logic          bus_oe
);
   localparam logic [DW-1:0] YB = DW'(Y_BLANK) << (DW - 8);
   localparam logic [DW-1:0] CB = DW'(C_BLANK) << (DW - 8);

   generate
      if (DW % PHASES_411 != 0 || DW < 8) begin : g_bad_width
         $error("yuv_bus_fmt: DW must be a multiple of 4 and at least 8");
      end
   endgenerate

   logic [PH_W-1:0] phase;
   fmt_e            fmt_cur;
   logic            line_start;
   logic [DW-1:0]   u_hold, v_hold, u_sel, v_sel, uv_next;

   yuv_phase_ctrl i_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_q      (ref_q),
      .href       (href),
      .fmt_sel    (fmt_e'(fmt_sel)),
      .phase      (phase),
      .fmt_cur    (fmt_cur),
      .line_start (line_start)
   );

   assign u_sel = (phase == '0) ? u_in : u_hold;
   assign v_sel = (phase == '0) ? v_in : v_hold;

   yuv_chroma_pack #(.DW(DW)) i_pack (
      .u_sel (u_sel),
      .v_sel (v_sel),
      .phase (phase),
      .fmt   (fmt_cur),
      .uv    (uv_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_out  <= YB;
         uv_out <= CB;
         u_hold <= '0;
         v_hold <= '0;
      end else if (ref_q) begin
         if (href) begin
            y_out  <= y_in;
            uv_out <= uv_next;
            if (phase == '0) begin
               u_hold <= u_in;
               v_hold <= v_in;
            end
         end else begin
            y_out  <= YB;
            uv_out <= CB;
         end
      end
   end

   assign bus_oe = ~oe_n;
endmodule

// File: rtl/yuv_bus_fmt_chk.sv
module yuv_bus_fmt_chk #(
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ref_q,
   input logic          href,
   input logic          oe_n,
   input logic          fmt_411,
   input logic [DW-1:0] y_in,
   input logic [DW-1:0] y_out,
   input logic [DW-1:0] uv_out,
   input logic          bus_oe
);
   // R2
   hold_when_unqualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_q |=> ($stable(y_out) && $stable(uv_out)));

   // R3
   blank_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_q && !href) |=> (y_out == DW'(16) << (DW - 8) && uv_out == DW'(128) << (DW - 8)));

   // R4
   luma_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_q && href) |=> (y_out == $past(y_in)));

   // R6
   low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_q && href && fmt_411) |=> (uv_out[DW/2-1:0] == '0));

   // R8
   always_comb begin
      if (rst_n) begin
         pad_enable_chk: assert (bus_oe == !oe_n);
      end
   end
endmodule

bind yuv_bus_fmt yuv_bus_fmt_chk #(.DW(DW)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ref_q   (ref_q),
   .href    (href),
   .oe_n    (oe_n),
   .fmt_411 (fmt_cur == yuv_fmt_pkg::FMT_411),
   .y_in    (y_in),
   .y_out   (y_out),
   .uv_out  (uv_out),
   .bus_oe  (bus_oe)
);

// File: tb/test_yuv_bus_fmt.sv
module test_yuv_bus_fmt;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_q = 1'b0, href = 1'b0, fmt_sel = 1'b0, oe_n = 1'b1;
   logic [7:0] y_in = '0, u_in = '0, v_in = '0;
   logic [7:0] y_out, uv_out;
   logic       bus_oe;

   int checks = 0, fails = 0;
   bit done = 0;

   // bench model state
   logic       m_hd = 0, m_fmt = 0;
   int         m_ph = 0;
   logic [7:0] m_uh = 0, m_vh = 0, e_y = 8'd16, e_uv = 8'd128;
   string      tag = "";

   yuv_bus_fmt i_yuv_bus_fmt (
      .clk(clk), .rst_n(rst_n), .ref_q(ref_q), .href(href), .fmt_sel(fmt_sel),
      .oe_n(oe_n), .y_in(y_in), .u_in(u_in), .v_in(v_in),
      .y_out(y_out), .uv_out(uv_out), .bus_oe(bus_oe)
   );

   always #10 clk = ~clk;

   function automatic logic [7:0] pack411(logic [7:0] u, logic [7:0] v, int p);
      return {u[7-2*p -: 2], v[7-2*p -: 2], 4'b0000};
   endfunction

   task automatic cmp(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // applies inputs, takes one clock edge, updates model and compares
   task automatic step(logic r, logic h, logic f, logic o, logic [7:0] y, logic [7:0] u, logic [7:0] v);
      string rq;
      logic [7:0] us, vs;
      @(negedge clk);
      ref_q = r; href = h; fmt_sel = f; oe_n = o; y_in = y; u_in = u; v_in = v;
      #1;
      cmp("R8 bus_oe", {7'b0, bus_oe}, {7'b0, ~o});
      @(posedge clk);
      if (r) begin
         if (h) begin
            if (!m_hd) begin m_ph = 0; m_fmt = f; end
            us = (m_ph == 0) ? u : m_uh;
            vs = (m_ph == 0) ? v : m_vh;
            if (m_ph == 0) begin m_uh = u; m_vh = v; end
            e_y = y;
            if (m_fmt) e_uv = pack411(us, vs, m_ph);
            else       e_uv = (m_ph == 0) ? us : vs;
            m_ph = (m_ph == (m_fmt ? 3 : 1)) ? 0 : m_ph + 1;
            rq = m_fmt ? "R6" : "R5";
         end else begin
            e_y = 8'd16; e_uv = 8'd128; m_ph = 0; rq = "R3";
         end
         m_hd = h;
      end else rq = "R2";
      #2;
      cmp({rq, " ", tag, " y(R4)"}, y_out, e_y);
      cmp({rq, " ", tag, " uv"}, uv_out, e_uv);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #3;
      cmp("R1 y reset", y_out, 8'd16);
      cmp("R1 uv reset", uv_out, 8'd128);
      @(negedge clk);
      rst_n = 1'b1;

      // directed: 4:2:2 line, U then V alternating
      tag = "dir422";
      for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 8'(8'h20 + i), 8'(8'h40 + i), 8'(8'hC0 + i));
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);

      // directed R9: a 3-sample 4:1:1 line, then a new 4:1:1 line
      tag = "R9";
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 8'(8'h80 + i), 8'hB4, 8'h6D);
      step(1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00);
      for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 8'(8'h90 + i), 8'(8'h1B + i), 8'(8'hE4 - i));
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);

      // directed R7: fmt_sel toggles mid-line, format stays 4:2:2
      tag = "R7";
      for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'(i > 0), 1'b0, 8'(i), 8'hF3, 8'h3C);
      step(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 8'h00);

      // directed R2: long strobe gap inside a line, enable toggling (R8)
      tag = "R2gap";
      step(1'b1, 1'b1, 1'b1, 1'b0, 8'h55, 8'hA5, 8'h5A);
      for (int i = 0; i < 4; i++) step(1'b0, 1'(i[0]), 1'b0, 1'(i[1]), 8'hFF, 8'hFF, 8'hFF);
      step(1'b1, 1'b1, 1'b0, 1'b1, 8'h66, 8'h00, 8'h00);
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);

      // constrained random lines
      tag = "rnd";
      for (int n = 0; n < 400; n++) begin
         int len = 1 + int'($urandom_range(13));
         for (int k = 0; k < 2 * len + 4; k++) begin
            logic r = ($urandom_range(9) == 0) ? 1'b0 : k[0] == 1'b0;
            logic h = (k < 2 * len);
            step(r, h, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
         end
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule